// File: doc/BRIEF.md
# Descriptor Ring Kick/Completion Tracker

This block keeps the three indices that describe a host-shared descriptor ring for one DMA direction. Software posts work by writing a kick index, the entry just past the last valid descriptor. While the channel is enabled and the consumer index differs from the kick index, the block asks a fetch engine to take the next descriptor. It presents the index of that descriptor and its address in host memory. Only one descriptor is outstanding at a time.

When the data mover reports that a descriptor's transfer has finished, the completion index advances by one. A done event is raised on the following cycle, so any reader that reacts to the event already sees the new completion index. Each of the three indices names the entry just past the last posted, fetched or finished descriptor. All three wrap at the selected ring size.

A parameter selects the receive variant. That variant accepts new descriptors only in groups of four. A misaligned kick value is rounded down, and a sticky error flag records the misuse.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset, kick, consumer and completion indices are 0, and fetch_req_o, done_o and kick_err_o are 0.
- R2: The 4-bit ring code selects 32 << code entries for codes 0 to 8; codes above 8 select 8192. Every index wraps modulo the selected size.
- R3: A kick write is reduced modulo the ring size and appears on kick_idx_o one cycle after the write.
- R4: With RX_MODE=1, bits 1:0 of the stored kick value are cleared, and a write whose bits 1:0 are nonzero sets kick_err_o, which stays set until reset. With RX_MODE=0, the value is stored unrounded and kick_err_o stays 0.
- R5: fetch_req_o is 1 exactly when the channel is enabled, the consumer index differs from the kick index, and no descriptor is in flight.
- R6: fetch_addr_o equals the base address with its low 11 bits forced to zero, plus fetch_idx_o × 16.
- R7: A cycle with fetch_req_o and fetch_gnt_i both high advances the consumer index by one, modulo the ring size. The descriptor is then in flight and fetch_req_o is low until it completes.
- R8: xfer_done_i while a descriptor is in flight advances cmpl_idx_o by one on the next edge. done_o pulses high for one cycle, one cycle after that. xfer_done_i with nothing in flight changes neither output.
- R9: Clearing cfg_enable_i stops new fetch requests, but an in-flight descriptor still completes and raises done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_enable_i | input | 1 | Channel enable |
| cfg_ring_code_i | input | 4 | Ring size code |
| cfg_base_i | input | ADDR_W | Descriptor table base address (low 11 bits ignored) |
| kick_we_i | input | 1 | Kick index write strobe |
| kick_wdata_i | input | IDX_W | Kick index write value |
| kick_idx_o | output | IDX_W | Stored kick index |
| kick_err_o | output | 1 | Sticky misaligned-kick flag (receive variant) |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_gnt_i | input | 1 | Fetch grant from the fetch engine |
| fetch_idx_o | output | IDX_W | Index of the descriptor offered |
| fetch_addr_o | output | ADDR_W | Host address of the descriptor offered |
| xfer_done_i | input | 1 | Data transfer for the in-flight descriptor finished |
| cmpl_idx_o | output | IDX_W | Completion index |
| done_o | output | 1 | Done event pulse |

## Verification
The assertions watch invariants that hold on every cycle:
- A request never offers the kick index, never appears while disabled, and always carries a 16-byte aligned address.
- A grant removes the request on the next cycle.
- The completion index moves only after a transfer-done input, and the done event only follows a completion update.
- The receive kick index stays a multiple of four.

Only the bench's scenarios can show the rest. It checks the exact sequence of indices and addresses handed out across wraps at two ring sizes and at the clamped largest size. It also covers rounding and the sticky flag, reduction of oversized kick values, and the disable-with-in-flight case.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned CODE_W       = 4;
  localparam int unsigned MIN_SIZE_LOG = 5;
  localparam int unsigned MAX_CODE     = 8;

  function automatic logic [31:0] size_mask(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
    return (32'd1 << (MIN_SIZE_LOG + 32'(c))) - 32'd1;
  endfunction
endpackage

// File: rtl/desc_kick_reg.sv
module desc_kick_reg #(
  parameter int unsigned IDX_W   = 13,
  parameter bit          RX_MODE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic [IDX_W-1:0] kick_o,
  output logic             err_o
);
  logic [IDX_W-1:0] wval;
  logic             bad;

  generate
    if (RX_MODE) begin : g_rx
      assign wval = wdata_i & mask_i & ~IDX_W'(3);
      assign bad  = |wdata_i[1:0];
    end else begin : g_tx
      assign wval = wdata_i & mask_i;
      assign bad  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_o <= '0;
      err_o  <= 1'b0;
    end else if (we_i) begin
      kick_o <= wval;
      if (bad) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl #(
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DESC_LOG2 = 4,
  parameter int unsigned ALIGN_W   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [IDX_W-1:0]  kick_i,
  input  logic [IDX_W-1:0]  mask_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              gnt_i,
  input  logic              retire_i,
  output logic              req_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o
);
  localparam int unsigned PAD_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  cons_q;
  logic              busy_q;
  logic              take;
  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] offs;

  assign req_o   = enable_i && (cons_q != kick_i) && !busy_q;
  assign take    = req_o && gnt_i;
  assign base_al = {base_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign offs    = {{PAD_W{1'b0}}, cons_q} << DESC_LOG2;
  assign addr_o  = base_al + offs;
  assign idx_o   = cons_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cons_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (take) begin
        cons_q <= (cons_q + IDX_W'(1)) & mask_i;
        busy_q <= 1'b1;
      end else if (retire_i) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/desc_cmpl_ctrl.sv
module desc_cmpl_ctrl #(
  parameter int unsigned IDX_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xfer_done_i,
  input  logic             busy_i,
  input  logic [IDX_W-1:0] mask_i,
  output logic             retire_o,
  output logic [IDX_W-1:0] cmpl_o,
  output logic             done_o
);
  logic published_q;

  assign retire_o = xfer_done_i && busy_i;

  // index first, event one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpl_o      <= '0;
      published_q <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      if (retire_o) cmpl_o <= (cmpl_o + IDX_W'(1)) & mask_i;
      published_q <= retire_o;
      done_o      <= published_q;
    end
  end
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker #(
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DESC_LOG2 = 4,
  parameter int unsigned ALIGN_W   = 11,
  parameter bit          RX_MODE   = 1'b1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_enable_i,
  input  logic [desc_ring_pkg::CODE_W-1:0] cfg_ring_code_i,
  input  logic [ADDR_W-1:0]                cfg_base_i,
  input  logic                             kick_we_i,
  input  logic [IDX_W-1:0]                 kick_wdata_i,
  output logic [IDX_W-1:0]                 kick_idx_o,
  output logic                             kick_err_o,
  output logic                             fetch_req_o,
  input  logic                             fetch_gnt_i,
  output logic [IDX_W-1:0]                 fetch_idx_o,
  output logic [ADDR_W-1:0]                fetch_addr_o,
  input  logic                             xfer_done_i,
  output logic [IDX_W-1:0]                 cmpl_idx_o,
  output logic                             done_o
);
  logic [31:0]      mask_full;
  logic [IDX_W-1:0] ring_mask;
  logic             busy;
  logic             retire;

  assign mask_full = desc_ring_pkg::size_mask(cfg_ring_code_i);
  assign ring_mask = mask_full[IDX_W-1:0];

  desc_kick_reg #(.IDX_W(IDX_W), .RX_MODE(RX_MODE)) u_kick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (kick_we_i),
    .wdata_i (kick_wdata_i),
    .mask_i  (ring_mask),
    .kick_o  (kick_idx_o),
    .err_o   (kick_err_o)
  );

  desc_fetch_ctrl #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_LOG2(DESC_LOG2), .ALIGN_W(ALIGN_W)
  ) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (cfg_enable_i),
    .kick_i   (kick_idx_o),
    .mask_i   (ring_mask),
    .base_i   (cfg_base_i),
    .gnt_i    (fetch_gnt_i),
    .retire_i (retire),
    .req_o    (fetch_req_o),
    .idx_o    (fetch_idx_o),
    .addr_o   (fetch_addr_o),
    .busy_o   (busy)
  );

  desc_cmpl_ctrl #(.IDX_W(IDX_W)) u_cmpl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xfer_done_i (xfer_done_i),
    .busy_i      (busy),
    .mask_i      (ring_mask),
    .retire_o    (retire),
    .cmpl_o      (cmpl_idx_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/desc_ring_checker.sv
module desc_ring_checker #(
  parameter int unsigned IDX_W     = 13,
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned DESC_LOG2 = 4,
  parameter bit          RX_MODE   = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_enable_i,
  input logic              fetch_req_o,
  input logic              fetch_gnt_i,
  input logic [IDX_W-1:0]  fetch_idx_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [IDX_W-1:0]  kick_idx_o,
  input logic              xfer_done_i,
  input logic [IDX_W-1:0]  cmpl_idx_o,
  input logic              done_o
);
  AST_REQ_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> fetch_idx_o != kick_idx_o); // R5
  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> cfg_enable_i); // R9
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> fetch_addr_o[DESC_LOG2-1:0] == '0); // R6
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o && fetch_gnt_i |=> !fetch_req_o); // R7
  AST_CMPL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmpl_idx_o) |-> $past(xfer_done_i)); // R8
  AST_EVENT_AFTER_PUBLISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$stable($past(cmpl_idx_o))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  generate
    if (RX_MODE) begin : g_rx_chk
      AST_RX_KICK_GROUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick_idx_o[1:0] == 2'b00); // R4
    end
  endgenerate
endmodule

bind desc_ring_tracker desc_ring_checker #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DESC_LOG2(DESC_LOG2), .RX_MODE(RX_MODE)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_enable_i (cfg_enable_i),
  .fetch_req_o  (fetch_req_o),
  .fetch_gnt_i  (fetch_gnt_i),
  .fetch_idx_o  (fetch_idx_o),
  .fetch_addr_o (fetch_addr_o),
  .kick_idx_o   (kick_idx_o),
  .xfer_done_i  (xfer_done_i),
  .cmpl_idx_o   (cmpl_idx_o),
  .done_o       (done_o)
);

// File: tb/desc_ring_tracker_bench.sv
module desc_ring_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 13;
  localparam int ADDR_W     = 64;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [3:0]        code = 4'd0;
  logic [ADDR_W-1:0] base = 64'h1234_5000_0000_07FF;
  logic              kwe = 1'b0;
  logic [IDX_W-1:0]  kdata = '0;
  logic [IDX_W-1:0]  kick_idx, fidx, cmpl;
  logic              kerr, freq, done;
  logic              gnt = 1'b0;
  logic              xdone = 1'b0;
  logic [ADDR_W-1:0] faddr;

  logic              tx_we = 1'b0;
  logic [IDX_W-1:0]  tx_kick, tx_fidx, tx_cmpl;
  logic              tx_err, tx_req, tx_done;
  logic [ADDR_W-1:0] tx_addr;

  int n_checks = 0;
  int n_err = 0;
  int exp_q[$];
  int kick_model = 0;
  bit auto_mode = 1'b1;
  bit busy = 1'b0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_ring_tracker #(.RX_MODE(1'b1)) u_desc_ring_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(en), .cfg_ring_code_i(code),
    .cfg_base_i(base), .kick_we_i(kwe), .kick_wdata_i(kdata),
    .kick_idx_o(kick_idx), .kick_err_o(kerr), .fetch_req_o(freq),
    .fetch_gnt_i(gnt), .fetch_idx_o(fidx), .fetch_addr_o(faddr),
    .xfer_done_i(xdone), .cmpl_idx_o(cmpl), .done_o(done)
  );

  desc_ring_tracker #(.RX_MODE(1'b0)) u_desc_ring_tracker_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_enable_i(1'b0), .cfg_ring_code_i(4'd0),
    .cfg_base_i(base), .kick_we_i(tx_we), .kick_wdata_i(13'd30),
    .kick_idx_o(tx_kick), .kick_err_o(tx_err), .fetch_req_o(tx_req),
    .fetch_gnt_i(1'b0), .fetch_idx_o(tx_fidx), .fetch_addr_o(tx_addr),
    .xfer_done_i(1'b0), .cmpl_idx_o(tx_cmpl), .done_o(tx_done)
  );

  function automatic int ring_mask();
    int c = (code > 4'd8) ? 8 : int'(code);
    return (32 << c) - 1;
  endfunction

  function automatic longint exp_addr(input int idx);
    return longint'((base & ~64'h7FF) + 64'(idx) * 64'd16);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  // driver: posts a kick and queues the descriptors it should release
  task automatic post(input int k, input string tag);
    int m = ring_mask();
    int kv = (k & m) & ~3;
    for (int i = kick_model; i != kv; i = (i + 1) & m) exp_q.push_back(i);
    kick_model = kv;
    @(negedge clk);
    kdata = IDX_W'(k);
    kwe = 1'b1;
    @(negedge clk);
    kwe = 1'b0;
    chk(kick_idx == IDX_W'(kv), tag, kick_idx, kv);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 80000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !busy && int'(cmpl) == kick_model && !done) break;
    end
  endtask

  // monitor + data mover model
  initial begin
    forever begin
      @(negedge clk);
      if (auto_mode && freq) begin
        int idx;
        int m;
        busy = 1'b1;
        m = ring_mask();
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected request", fidx, -1);
          idx = int'(fidx);
        end else begin
          idx = exp_q.pop_front();
        end
        chk(fidx == IDX_W'(idx), "R7 fetch index order", fidx, idx);
        chk(faddr == 64'(exp_addr(idx)), "R6 fetch address", faddr, exp_addr(idx));
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        chk(!freq, "R7 single in flight", freq, 0);
        repeat (2) @(negedge clk);
        xdone = 1'b1;
        @(negedge clk);
        xdone = 1'b0;
        chk(cmpl == IDX_W'((idx + 1) & m), "R8 completion index", cmpl, (idx + 1) & m);
        chk(!done, "R8 event not before publish", done, 0);
        @(negedge clk);
        chk(done, "R8 done event", done, 1);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    chk(kick_idx == 0 && cmpl == 0 && fidx == 0, "R1 reset indices", {kick_idx, cmpl, fidx}, 0);
    chk(!freq && !done && !kerr, "R1 reset flags", {freq, done, kerr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;

    post(8, "R3 kick capture");
    wait_idle();
    chk(cmpl == 13'd8, "R8 drained to kick", cmpl, 8);

    post(30, "R4 rx rounding");
    chk(kerr, "R4 sticky error set", kerr, 1);
    wait_idle();

    post(4, "R2 wrap at 32");
    wait_idle();
    chk(cmpl == 13'd4, "R2 completion wrapped", cmpl, 4);
    chk(kerr, "R4 error stays set", kerr, 1);

    post(40, "R3 kick reduced modulo ring");
    wait_idle();

    code = 4'd1;
    post(60, "R2 size 64 kick");
    wait_idle();
    post(8, "R2 wrap at 64");
    wait_idle();
    chk(cmpl == 13'd8, "R2 completion wrapped at 64", cmpl, 8);

    code = 4'd9;
    post(8188, "R2 clamped code kick");
    wait_idle();
    post(4, "R2 wrap at 8192");
    wait_idle();
    chk(cmpl == 13'd4, "R2 completion wrapped at 8192", cmpl, 4);

    // disable behaviour with manual handshake
    auto_mode = 1'b0;
    en = 1'b0;
    post(8, "R9 kick while disabled");
    repeat (3) @(negedge clk);
    chk(!freq, "R9 no request while disabled", freq, 0);
    en = 1'b1;
    @(negedge clk);
    chk(freq, "R5 request after enable", freq, 1);
    idx = exp_q.pop_front();
    chk(fidx == IDX_W'(idx), "R7 manual fetch index", fidx, idx);
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!freq, "R9 disabled with work pending", freq, 0);
    xdone = 1'b1;
    @(negedge clk);
    xdone = 1'b0;
    chk(cmpl == 13'd5, "R9 in-flight completes", cmpl, 5);
    @(negedge clk);
    chk(done, "R9 done after disable", done, 1);
    en = 1'b1;
    auto_mode = 1'b1;
    wait_idle();
    chk(cmpl == 13'd8, "R9 resume drains", cmpl, 8);

    // stray done with nothing in flight
    @(negedge clk);
    xdone = 1'b1;
    @(negedge clk);
    xdone = 1'b0;
    chk(cmpl == 13'd8, "R8 stray done ignored", cmpl, 8);
    @(negedge clk);
    chk(!done, "R8 no event for stray done", done, 0);

    // transmit variant: no rounding, no error
    tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
    chk(tx_kick == 13'd30, "R4 tx kick unrounded", tx_kick, 30);
    chk(!tx_err, "R4 tx no error", tx_err, 0);

    finish_run();
  end
endmodule